// File: doc/BRIEF.md
# IO Coherency Aperture Decoder

This block sits on the path of memory transactions issued by IO masters and decides, one transaction at a time, whether the address lies inside a single programmed coherency window. Transactions inside the window are marked coherent, so that the fabric sends them to the port that keeps the shared cache consistent. All other transactions are marked non-coherent and go straight to memory. Each decision is registered, and valid/ready flow control is used on both the upstream and downstream sides.

Software programs the window through a small register port. The window base is stored as a 4 KB page number. The window size is stored as a logarithmic code. There is a one-bit control that permits partial-line transactions, and a one-bit enable. An enable request made with a misaligned base or an oversized code is refused, and a sticky error flag is raised. Coherent routing also depends on two system conditions: a second-level shared cache must be present, and the level-one data cache must be on. The block reports the state of that prerequisite on a status output.

Top module: `io_aperture_router`

## Requirements
- R1: After reset, all four registers read as zero, `cfg_err` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: A size code C selects a window of 2^(C+12) bytes, i.e. 2^(C+2) KB (code 17 is 512 MB, code 18 is 1 GB). An address is inside the window when every address bit at position C+12 or above equals the same bit of the base address.
- R3: Register index 0 holds the base as a page number, which is the start address shifted right by 12. Register index 1 holds the size code in bits [4:0].
- R4: While the stored enable is 0, every transaction leaves with `out_coherent` = 0, whatever its address.
- R5: Writing 1 to bit 0 of register index 3 while the base page has any of its low C bits set, or while C+12 exceeds the address width, leaves the enable at 0 and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R6: `prereq_ok` equals `l2_present` AND `l1d_on`. While `prereq_ok` is 0, accepted transactions are marked non-coherent.
- R7: A transaction accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_valid`/`out_addr`/`out_coherent` after that edge. While `out_valid` is 1 and `out_ready` is 0, those outputs hold and `in_ready` is 0.
- R8: Bit 0 of register index 2 is driven unchanged onto `partial_ok`, and it has no effect on routing.
- R9: While the enable is 1, writes to register indices 0 and 1 are ignored.
- R10: A transaction accepted on the same edge as a register write is routed by the configuration held before that edge.
- R11: Reading register index 3 returns the enable in bit 0 and `cfg_err` in bit 1. Reading index 2 returns the partial bit in bit 0. All unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index for both write and read |
| reg_wdata | input | ADDR_W-12 | Register write data |
| reg_rdata | output | ADDR_W-12 | Read data of the register selected by `reg_addr` |
| l2_present | input | 1 | Shared second-level cache is present |
| l1d_on | input | 1 | Level-one data cache is enabled |
| in_valid | input | 1 | Upstream transaction valid |
| in_ready | output | 1 | Block can accept a transaction |
| in_addr | input | ADDR_W | Upstream transaction address |
| out_valid | output | 1 | Routed transaction valid |
| out_ready | input | 1 | Downstream accepts the routed transaction |
| out_addr | output | ADDR_W | Routed transaction address |
| out_coherent | output | 1 | 1 routes to the coherent port, 0 routes to memory |
| partial_ok | output | 1 | Partial-line transactions permitted |
| prereq_ok | output | 1 | Prerequisite for coherent routing is met |
| cfg_err | output | 1 | Sticky error for a refused enable request |

## Verification
Two events can land on the same clock edge: a write that changes the enable, and the acceptance of a transaction whose routing depends on that enable. The bench provokes this by driving the enable write and an in-window transaction in one cycle. It expects that transaction to leave non-coherent, because it is judged by the old enable. It then reads the enable back as set, and checks that the next in-window transaction is routed coherent. A second overlap arises while the output is stalled: a transaction waits on the input and must not overwrite the held output. The bench checks that the held address and decision stay fixed until `out_ready` returns.

// File: rtl/ioap_pkg.sv
package ioap_pkg;

  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    IDX_BASE = 2'd0,
    IDX_SIZE = 2'd1,
    IDX_PART = 2'd2,
    IDX_CTRL = 2'd3
  } ioap_idx_e;

  // log2 of the window size in bytes for a given size code
  function automatic int window_log2(input int code);
    return code + PAGE_SHIFT;
  endfunction

  // an address bit takes part in the compare when it is at or above the window log2
  function automatic logic compare_bit(input int idx, input int lg);
    return (idx >= lg);
  endfunction

  // a base page bit must be zero when it lies inside the window offset
  function automatic logic offset_page_bit(input int idx, input int code);
    return (idx < code);
  endfunction

endpackage

// File: rtl/ioap_cfg_regs.sv
module ioap_cfg_regs
  import ioap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [1:0]                   idx,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] wdata,
  output logic [ADDR_W-PAGE_SHIFT-1:0] rdata,
  output logic [ADDR_W-PAGE_SHIFT-1:0] base_page,
  output logic [CODE_W-1:0]            size_code,
  output logic                         partial,
  output logic                         enable,
  output logic                         err,
  output logic                         cfg_good
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [PAGE_W-1:0] offset_bits;
  logic              fits;
  logic              aligned;

  always_comb begin
    for (int i = 0; i < PAGE_W; i++) begin
      offset_bits[i] = offset_page_bit(i, int'(size_code));
    end
    fits     = (window_log2(int'(size_code)) <= ADDR_W);
    aligned  = ((base_page & offset_bits) == '0);
    cfg_good = fits && aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_page <= '0;
      size_code <= '0;
      partial   <= 1'b0;
      enable    <= 1'b0;
      err       <= 1'b0;
    end else if (we) begin
      case (ioap_idx_e'(idx))
        IDX_BASE: if (!enable) base_page <= wdata;
        IDX_SIZE: if (!enable) size_code <= wdata[CODE_W-1:0];
        IDX_PART: partial <= wdata[0];
        IDX_CTRL: begin
          if (wdata[0]) begin
            enable <= cfg_good;
            if (!cfg_good) err <= 1'b1;
          end else begin
            enable <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (ioap_idx_e'(idx))
      IDX_BASE: rdata = base_page;
      IDX_SIZE: rdata[CODE_W-1:0] = size_code;
      IDX_PART: rdata[0] = partial;
      IDX_CTRL: rdata[1:0] = {err, enable};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/ioap_window_match.sv
module ioap_window_match
  import ioap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] base_page,
  input  logic [CODE_W-1:0]            size_code,
  output logic                         hit
);
  logic [ADDR_W-1:0] cmp_bits;
  logic [ADDR_W-1:0] base_addr;

  assign base_addr = {base_page, {PAGE_SHIFT{1'b0}}};

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      cmp_bits[i] = compare_bit(i, window_log2(int'(size_code)));
    end
    hit = (((addr ^ base_addr) & cmp_bits) == '0);
  end

endmodule

// File: rtl/ioap_route_stage.sv
module ioap_route_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              coh_now,
  output logic              in_ready,
  output logic              accept,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_coherent
);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_coherent <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr     <= in_addr;
        out_coherent <= coh_now;
      end
    end
  end

endmodule

// File: rtl/io_aperture_router.sv
module io_aperture_router
  import ioap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_addr,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] reg_wdata,
  output logic [ADDR_W-PAGE_SHIFT-1:0] reg_rdata,
  input  logic                         l2_present,
  input  logic                         l1d_on,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [ADDR_W-1:0]            in_addr,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [ADDR_W-1:0]            out_addr,
  output logic                         out_coherent,
  output logic                         partial_ok,
  output logic                         prereq_ok,
  output logic                         cfg_err
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [PAGE_W-1:0] base_q;
  logic [CODE_W-1:0] code_q;
  logic              en_q;
  logic              cfg_good;
  logic              hit;
  logic              coh_now;
  logic              accept;

  ioap_cfg_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .idx       (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .base_page (base_q),
    .size_code (code_q),
    .partial   (partial_ok),
    .enable    (en_q),
    .err       (cfg_err),
    .cfg_good  (cfg_good)
  );

  ioap_window_match #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_match (
    .addr      (in_addr),
    .base_page (base_q),
    .size_code (code_q),
    .hit       (hit)
  );

  assign prereq_ok = l2_present && l1d_on;
  assign coh_now   = en_q && prereq_ok && hit;

  ioap_route_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_addr      (in_addr),
    .coh_now      (coh_now),
    .in_ready     (in_ready),
    .accept       (accept),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_addr     (out_addr),
    .out_coherent (out_coherent)
  );

endmodule

// File: rtl/ioap_checker.sv
module ioap_checker #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5,
  parameter int PAGE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              hit,
  input logic              en_q,
  input logic              prereq_ok,
  input logic              cfg_good,
  input logic              cfg_err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_coherent,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [PAGE_W-1:0] base_q,
  input logic [CODE_W-1:0] code_q
);

  assert_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !out_coherent);

  assert_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !en_q) |=> !out_coherent);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(cfg_good));

  assert_prereq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !prereq_ok) |=> !out_coherent);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_coherent)));

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1)) |=> ($stable(base_q) && $stable(code_q)));

endmodule

bind io_aperture_router ioap_checker #(
  .ADDR_W (ADDR_W),
  .CODE_W (CODE_W),
  .PAGE_W (PAGE_W)
) u_ioap_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .hit          (hit),
  .en_q         (en_q),
  .prereq_ok    (prereq_ok),
  .cfg_good     (cfg_good),
  .cfg_err      (cfg_err),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_addr     (out_addr),
  .out_coherent (out_coherent),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .base_q       (base_q),
  .code_q       (code_q)
);

// File: tb/test_io_aperture_router.sv
module test_io_aperture_router;

  localparam int ADDR_W = 32;
  localparam int CODE_W = 5;
  localparam int PAGE_W = ADDR_W - 12;

  // {base page, size code, address, expected coherent}
  localparam logic [57:0] VEC [9] = '{
    {20'h00010, 5'd0,  32'h0001_0000, 1'b1},
    {20'h00010, 5'd0,  32'h0001_0FFF, 1'b1},
    {20'h00010, 5'd0,  32'h0001_1000, 1'b0},
    {20'h00010, 5'd0,  32'h0000_FFFF, 1'b0},
    {20'h20000, 5'd17, 32'h3FFF_FFFF, 1'b1},
    {20'h20000, 5'd17, 32'h4000_0000, 1'b0},
    {20'h40000, 5'd18, 32'h7FFF_FFFC, 1'b1},
    {20'h40000, 5'd18, 32'h3FFF_FFFF, 1'b0},
    {20'h00000, 5'd20, 32'hFFFF_FFFF, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [PAGE_W-1:0] reg_wdata = '0;
  logic [PAGE_W-1:0] reg_rdata;
  logic              l2_present = 1'b1;
  logic              l1d_on = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [ADDR_W-1:0] out_addr;
  logic              out_coherent;
  logic              partial_ok;
  logic              prereq_ok;
  logic              cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  io_aperture_router #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_io_aperture_router (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .l2_present(l2_present),
    .l1d_on(l1d_on), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_coherent(out_coherent), .partial_ok(partial_ok), .prereq_ok(prereq_ok),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [PAGE_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [PAGE_W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
    chk(out_coherent == exp, req, 64'(out_coherent), 64'(exp));
  endtask

  task automatic setup(input logic [PAGE_W-1:0] page, input logic [4:0] code);
    wr(2'd3, '0);
    wr(2'd0, page);
    wr(2'd1, PAGE_W'(code));
    wr(2'd3, PAGE_W'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PAGE_W-1:0] d;
    do_reset();

    // R1 / R11 reset state through the read port
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      chk(d == '0, "R1 reset register", 64'(d), 64'd0);
    end
    chk(!out_valid && in_ready && !cfg_err, "R1 reset outputs",
        64'({out_valid, in_ready, cfg_err}), 64'b010);

    // R2 / R3 vector table
    for (int i = 0; i < 9; i++) begin
      logic [57:0] v;
      v = VEC[i];
      setup(v[57:38], v[37:33]);
      rd(2'd0, d);
      chk(d == v[57:38], "R3 base page readback", 64'(d), 64'(v[57:38]));
      rd(2'd1, d);
      chk(d == PAGE_W'(v[37:33]), "R3 size code readback", 64'(d), 64'(v[37:33]));
      send(v[32:1], v[0], "R2 window decode");
    end

    // R4 enable off: address inside the last programmed window
    wr(2'd3, '0);
    send(32'h1234_5678, 1'b0, "R4 disabled routing");

    // R9 writes ignored while enabled
    setup(20'h00010, 5'd0);
    wr(2'd0, 20'h00555);
    wr(2'd1, 20'd3);
    rd(2'd0, d);
    chk(d == 20'h00010, "R9 base locked", 64'(d), 64'h10);
    rd(2'd1, d);
    chk(d == '0, "R9 size locked", 64'(d), 64'd0);

    // R6 prerequisite
    l2_present = 1'b0;
    #1 chk(prereq_ok == 1'b0, "R6 prereq low", 64'(prereq_ok), 64'd0);
    send(32'h0001_0010, 1'b0, "R6 no shared cache");
    l2_present = 1'b1; l1d_on = 1'b0;
    send(32'h0001_0010, 1'b0, "R6 l1 data cache off");
    l1d_on = 1'b1;
    #1 chk(prereq_ok == 1'b1, "R6 prereq high", 64'(prereq_ok), 64'd1);

    // R8 partial pass-through, no routing effect
    wr(2'd2, PAGE_W'(1));
    chk(partial_ok == 1'b1, "R8 partial output", 64'(partial_ok), 64'd1);
    rd(2'd2, d);
    chk(d == PAGE_W'(1), "R11 partial readback", 64'(d), 64'd1);
    send(32'h0001_0020, 1'b1, "R8 routing unchanged");
    send(32'h0002_0020, 1'b0, "R8 routing unchanged");

    // R10 enable write and transaction in the same cycle
    wr(2'd3, '0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = PAGE_W'(1);
    in_valid = 1'b1; in_addr = 32'h0001_0040;
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0;
    chk(out_valid && !out_coherent, "R10 old enable used",
        64'({out_valid, out_coherent}), 64'b10);
    rd(2'd3, d);
    chk(d == PAGE_W'(1), "R10 enable took effect", 64'(d), 64'd1);
    send(32'h0001_0040, 1'b1, "R10 next transaction coherent");

    // R7 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h0001_0100;
    @(negedge clk);
    in_addr = 32'h0005_0000;
    chk(out_valid && !in_ready && out_addr == 32'h0001_0100, "R7 stall first",
        64'(out_addr), 64'h0001_0100);
    @(negedge clk);
    chk(out_valid && out_coherent && out_addr == 32'h0001_0100, "R7 stall held",
        64'(out_addr), 64'h0001_0100);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && !out_coherent && out_addr == 32'h0005_0000, "R7 next after release",
        64'(out_addr), 64'h0005_0000);

    // R5 misaligned base
    do_reset();
    wr(2'd0, 20'h00011);
    wr(2'd1, 20'd1);
    wr(2'd3, PAGE_W'(1));
    rd(2'd3, d);
    chk(d == PAGE_W'(2), "R5 misaligned refused", 64'(d), 64'd2);
    chk(cfg_err == 1'b1, "R5 error flag", 64'(cfg_err), 64'd1);
    send(32'h0001_1000, 1'b0, "R5 stays non-coherent");
    wr(2'd0, 20'h00010);
    wr(2'd3, PAGE_W'(1));
    rd(2'd3, d);
    chk(d == PAGE_W'(3), "R5 sticky after good enable", 64'(d), 64'd3);

    // R5 oversize code
    do_reset();
    wr(2'd1, 20'd21);
    wr(2'd3, PAGE_W'(1));
    rd(2'd3, d);
    chk(d == PAGE_W'(2), "R5 oversize refused", 64'(d), 64'd2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule